// File: doc/BRIEF.md
# Compare-Match PWM Generator

This block produces a fixed-period pulse-width-modulated signal from a free-running up-counter and a compare value. The counter steps once per count tick (a one-cycle enable strobe supplied by a prescaler elsewhere) while the run flag is set. It wraps from its all-ones value back to zero, so one PWM period is 2^CNT_W ticks: 256 at the default width of 8 bits.

An internal source level is high while the counter is at or below the active compare value, and low from the next count up to the wrap. The pin output is that level registered once more on the count tick, so it trails the source by one count tick. Software writes a new compare value at any time. The value is parked in a buffer and only becomes active at the wrap, so a period already under way is never cut short. A one-tick overflow flag marks each wrap. Clearing the run flag parks the counter at zero and drives the pin and flag low.

Top module: `pwm8_gen`

## Requirements
- R1: The counter counts 0x00 up to 0xFF and wraps to 0x00, so with a tick on every clock one PWM period, measured from an enable, is 256 clocks and contains exactly one overflow flag.
- R2: The counter advances by one only on clocks where both `run_en` and `cnt_tick` are 1; with `run_en` 1 and `cnt_tick` 0, the counter, `pwm_out` and `ovf_pulse` keep their values.
- R3: The source level is 1 for counter values 0x00 through the active compare value inclusive and 0 above it, so one period holds compare+1 high ticks (all 256 for compare 0xFF).
- R4: On each count tick, `pwm_out` takes the source level of the counter value before that tick, so it lags the source by exactly one count tick.
- R5: A value written with `cmp_wr` is held in a buffer and becomes the active compare only on the tick that wraps the counter from 0xFF to 0x00; a write in that same clock takes effect at that wrap; while `run_en` is 0 a written value becomes active on the next clock.
- R6: `ovf_pulse` is 1 for exactly the one count tick that follows the counter's wrap from 0xFF to 0x00, and 0 otherwise.
- R7: On the clock after `run_en` is sampled 0, the counter is 0x00 and `pwm_out` and `ovf_pulse` are 0, and they stay so while `run_en` is 0.
- R8: After reset (`rst_n` low), the counter, the delayed output, the overflow flag and both compare registers are 0, so the first enabled period holds one high tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Timer run flag; 0 parks the counter at zero |
| cnt_tick | input | 1 | Count-clock enable strobe, one clock wide |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | CNT_W | Compare value to write (high period minus one) |
| pwm_out | output | 1 | PWM pin level, source delayed by one count tick |
| ovf_pulse | output | 1 | High for one count tick after each counter wrap |

## Verification
The bench measures the high time of a full period for compare values 0x00, 0x03, 0x80 and 0xFF. A design with an off-by-one in the match would give one tick too many or too few, and one that treats 0xFF as a special case would drop the all-high period. A compare value is written in the middle of a period, and another in the exact clock of the wrap. Loading the buffer straight away would truncate the running period, and missing the coinciding write would delay the new duty by a whole period. Sparse ticks and a mid-run disable check that the counter, the one-tick delay and the overflow flag move only on count ticks and clear at once. A model that skipped the delay register would shift every edge by one tick.

// File: rtl/pwm8_pkg.sv
// Package: pwm8_pkg
// Shared constants and helpers for the compare-match PWM generator.
// Assumes: widths are passed per instance; only defaults live here.
package pwm8_pkg;

    // Default counter width; one period spans 2**PWM_CNT_W_DEF ticks.
    localparam int PWM_CNT_W_DEF = 8;

    // Source level for a counter value against a compare value (inclusive match).
    function automatic logic src_level(input logic [31:0] cnt, input logic [31:0] cmp);
        return (cnt <= cmp);
    endfunction

endpackage

// File: rtl/pwm8_counter.sv
// Module: pwm8_counter
// Free-running binary up-counter that steps once per count tick while the
// run flag is set and wraps from all-ones to zero.
// Assumes: cnt_tick is a single-clock strobe; run_en low parks the count at 0.
module pwm8_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_tick,
    output logic [W-1:0] cnt_q,
    output logic         step,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    // Qualified count step and the step that wraps the counter.
    always_comb begin
        step = run_en && cnt_tick;
        wrap = step && (cnt_q == CNT_TOP);
    end

    // Counter register: cleared on reset or stop, stepped on qualified ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm8_cmp_reg.sv
// Module: pwm8_cmp_reg
// Double-buffered compare register. Writes land in a buffer; the active
// value is refreshed from the buffer at the counter wrap, or on every clock
// while the timer is stopped. A write in the wrap clock is taken directly.
// Assumes: wrap is asserted only in the clock that steps the counter to 0.
module pwm8_cmp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         wrap,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_act
);
    logic [W-1:0] cmp_buf;
    logic [W-1:0] buf_next;
    logic         load_act;

    // Next buffer content and the moment it may reach the active register.
    always_comb begin
        buf_next = cmp_wr ? cmp_wdata : cmp_buf;
        load_act = wrap || !run_en;
    end

    // Buffer register: captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf <= '0;
        end else begin
            cmp_buf <= buf_next;
        end
    end

    // Active register: updated only at a period boundary or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act <= '0;
        end else if (load_act) begin
            cmp_act <= buf_next;
        end
    end

endmodule

// File: rtl/pwm8_wave.sv
// Module: pwm8_wave
// Forms the source level from counter and compare, then registers it once
// per count tick to drive the pin; also registers the overflow flag.
// Assumes: step and wrap come from pwm8_counter in the same clock.
module pwm8_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         step,
    input  logic         wrap,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cmp_act,
    output logic         pwm_out,
    output logic         ovf_pulse
);
    import pwm8_pkg::*;

    logic src_lvl;
    logic dly_q;
    logic ovf_q;

    // Source level: high from zero through the compare value inclusive.
    always_comb begin
        src_lvl = src_level(32'(cnt_q), 32'(cmp_act));
    end

    // One-tick delay of the source level and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (!run_en) begin
            dly_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (step) begin
            dly_q <= src_lvl;
            ovf_q <= wrap;
        end
    end

    // Drive the outputs straight from registers.
    always_comb begin
        pwm_out   = dly_q;
        ovf_pulse = ovf_q;
    end

endmodule

// File: rtl/pwm8_gen.sv
// Module: pwm8_gen
// Top of the compare-match PWM generator: counter, buffered compare
// register and output shaping. Period is 2**CNT_W count ticks; high time is
// compare+1 ticks; the pin lags the internal source by one count tick.
// Assumes: synchronous active-low reset; cnt_tick is a one-clock strobe.
module pwm8_gen #(
    parameter int CNT_W = pwm8_pkg::PWM_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cnt_tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             pwm_out,
    output logic             ovf_pulse
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_act;
    logic             step;
    logic             wrap;

    pwm8_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .cnt_tick (cnt_tick),
        .cnt_q    (cnt_q),
        .step     (step),
        .wrap     (wrap)
    );

    pwm8_cmp_reg #(.W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .wrap      (wrap),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cmp_act   (cmp_act)
    );

    pwm8_wave #(.W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .step      (step),
        .wrap      (wrap),
        .cnt_q     (cnt_q),
        .cmp_act   (cmp_act),
        .pwm_out   (pwm_out),
        .ovf_pulse (ovf_pulse)
    );

endmodule

// File: rtl/pwm8_gen_chk.sv
// Module: pwm8_gen_chk
// Property checker for pwm8_gen, attached by bind below.
// Assumes: sampled on the rising clock, reset synchronous active low.
module pwm8_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         cnt_tick,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cmp_act,
    input logic         pwm_out,
    input logic         ovf_pulse
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // R1: a qualified tick moves the counter up by one, wrapping at the top
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    // R2: without a tick the counter and both outputs hold
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cnt_tick) |=> ($stable(cnt_q) && $stable(pwm_out) && $stable(ovf_pulse)));

    // R4: pin follows the previous source level after each tick
    a_r4_one_tick_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick) |=> (pwm_out == ($past(cnt_q) <= $past(cmp_act))));

    // R5: active compare only changes at a wrap or while stopped
    a_r5_cmp_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !(cnt_tick && cnt_q == TOP)) |=> $stable(cmp_act));

    // R6: overflow flag reflects whether the last tick wrapped
    a_r6_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick) |=> (ovf_pulse == ($past(cnt_q) == TOP)));

    // R7: stopping parks the counter and drives the outputs low
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0 && !pwm_out && !ovf_pulse));

endmodule

bind pwm8_gen pwm8_gen_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cnt_tick  (cnt_tick),
    .cnt_q     (cnt_q),
    .cmp_act   (cmp_act),
    .pwm_out   (pwm_out),
    .ovf_pulse (ovf_pulse)
);

// File: tb/test_pwm8_gen.sv
// Bench: test_pwm8_gen
// Scoreboard bench: the driver task applies one clock of stimulus, advances
// a requirement-level model and queues the expected outputs; the monitor
// pops and compares on the falling edge. Directed windows tally high time.
module test_pwm8_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic       cnt_tick;
    logic       cmp_wr;
    logic [7:0] cmp_wdata;
    logic       pwm_out;
    logic       ovf_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int hi_n    = 0;
    int ov_n    = 0;
    bit done    = 0;

    // Expected outputs {pwm, ovf} and their requirement tags.
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Model state, reset values per R8.
    logic [7:0] m_cnt = 8'h00;
    logic [7:0] m_buf = 8'h00;
    logic [7:0] m_act = 8'h00;
    logic       m_dly = 1'b0;
    logic       m_ovf = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pwm8_gen i_pwm8_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cnt_tick  (cnt_tick),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .pwm_out   (pwm_out),
        .ovf_pulse (ovf_pulse)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: one clock of stimulus, then model update and expectation push.
    task automatic step(input logic tk, input logic en, input logic wr,
                        input logic [7:0] d, input string tag);
        logic [7:0] nbuf;
        #1;
        cnt_tick  = tk;
        run_en    = en;
        cmp_wr    = wr;
        cmp_wdata = d;
        @(posedge clk);
        nbuf = wr ? d : m_buf;
        if (!en) begin
            m_cnt = 8'h00; m_dly = 1'b0; m_ovf = 1'b0; m_act = nbuf;
        end else if (tk) begin
            m_dly = (m_cnt <= m_act);
            m_ovf = (m_cnt == 8'hFF);
            if (m_cnt == 8'hFF) m_act = nbuf;
            m_cnt = m_cnt + 8'h01;
        end
        m_buf = nbuf;
        exp_q.push_back({m_dly, m_ovf});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectations and tally high/overflow ticks.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(pwm_out),   int'(e[1]), t, "pwm_out");
            chk(int'(ovf_pulse), int'(e[0]), t, "ovf_pulse");
        end
        if (pwm_out)   hi_n++;
        if (ovf_pulse) ov_n++;
    end

    // Stop, optionally write, enable and measure one full period.
    task automatic measure(input logic wr, input logic [7:0] d, input int exp_hi, input string tag);
        step(1'b1, 1'b0, wr, d, tag);
        @(negedge clk); #1;
        hi_n = 0; ov_n = 0;
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 1'b0, 8'h00, tag);
        @(negedge clk); #1;
        chk(hi_n, exp_hi, tag, "high ticks per period (R3)");
        chk(ov_n, 1, "R1", "overflows per period");
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b1; cnt_tick = 1'b1; cmp_wr = 1'b0; cmp_wdata = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the pins
        chk(int'(pwm_out),   0, "R8", "pwm_out in reset");
        chk(int'(ovf_pulse), 0, "R8", "ovf_pulse in reset");
        #1; rst_n = 1'b1;
        @(posedge clk);

        // R8 / R3: reset compare of zero gives one high tick
        measure(1'b0, 8'h00, 1, "R8");
        // R3 / R5: written while stopped, active at once
        measure(1'b1, 8'h03, 4, "R3");
        measure(1'b1, 8'h80, 129, "R3");
        measure(1'b1, 8'hFF, 256, "R3");

        // R5: mid-period write must not disturb the running period
        measure(1'b1, 8'h10, 17, "R5");
        for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        step(1'b1, 1'b1, 1'b1, 8'hC8, "R5");
        while (m_cnt != 8'h00) step(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        @(negedge clk); #1;
        hi_n = 0;
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        @(negedge clk); #1;
        chk(hi_n, 201, "R5", "high ticks after buffered mid-period write");

        // R5: write in the very clock of the wrap takes effect at that wrap
        while (m_cnt != 8'hFF) step(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        step(1'b1, 1'b1, 1'b1, 8'd20, "R5");
        @(negedge clk); #1;
        hi_n = 0; ov_n = 0;
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        @(negedge clk); #1;
        chk(hi_n, 21, "R5", "high ticks after write on wrap");
        chk(ov_n, 1, "R6", "overflow ticks after write on wrap");

        // R2 / R4 / R6: sparse ticks, every third clock
        for (int i = 0; i < 900; i++)
            step((i % 3) == 0, 1'b1, (i == 400), 8'h07, "R2");

        // R7: stop mid-run, hold stopped, then restart
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R7");
        for (int i = 0; i < 20; i++) step(i[0], 1'b0, 1'b0, 8'h00, "R7");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R7");

        // R4: alternating tick gaps around the compare edge
        for (int i = 0; i < 600; i++)
            step((i % 5) != 2, 1'b1, 1'b0, 8'h00, "R4");

        step(1'b0, 1'b1, 1'b0, 8'h00, "R2");
        @(negedge clk); #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule